// File: doc/BRIEF.md
# Luma DC Hadamard Dequantizer

This block takes the sixteen DC coefficients of a 16x16 luma macroblock, arranged as a 4x4 array, and applies a two-dimensional 4-point Walsh-Hadamard transform to them. The transform is applied first along each row and then along each column of the row results. Every transformed value is then scaled by a quantizer multiplier, rounded and saturated.

The sixteen results are emitted as a write stream, one per clock. Each write carries a coefficient address and a value. The address points at coefficient 0 of one of sixteen 4x4 residual blocks laid out back to back. The blocks are visited in an interleaved order that follows the 8x8 quadrant structure, not plain raster order.

A single-cycle `start` pulse latches the coefficient array and the multiplier. A single-cycle `done` pulse follows the last write. The caller derives the multiplier from the quantizer parameter beforehand, and the per-block inverse transforms run afterwards on the blocks this block has filled in.

Top module: `ldc_hadamard_dequant`

## Requirements
- R1: A `start` pulse seen while idle latches `coef_in` and `qmul`. In the next cycle the block begins emitting exactly sixteen writes, one on each of sixteen consecutive cycles, with `wr_valid` high.
- R2: The 1-D transform maps inputs (a,b,c,d) to outputs k=0..3 as a+b+c+d, a+b-c-d, a-b-c+d and a-b+c-d. Input element (r,c) sits at `coef_in[(4r+c)*16 +: 16]`. The transform is applied to every row r, giving g[r][k]. It is then applied down every column j of g, giving result f[k][j].
- R3: All transform sums are formed in 16-bit two's complement arithmetic and wrap on overflow.
- R4: When `qmul` <= 32767, each result value v becomes (v*qmul + 128) >> 8, using an arithmetic shift on an exact product.
- R5: When `qmul` > 32767, each result value v becomes (v*(qmul>>7) + 1) >> 1, using an arithmetic shift. `qmul` is a 22-bit unsigned value.
- R6: The scaled value is clamped to the range [-32768, 32767] before it is written.
- R7: Write n (n=0..15) carries f[n/4][n%4]. Its destination block is (i>>1)*8 + (j>>1)*4 + (i&1)*2 + (j&1), with i=n/4 and j=n%4. This gives the block sequence 0,1,4,5,2,3,6,7,8,9,12,13,10,11,14,15. `wr_addr` equals block*16, which is coefficient 0 of that block.
- R8: `done` is high for exactly one cycle: the cycle after the sixteenth write. `wr_valid` is low in that cycle.
- R9: A `start` pulse that arrives while writes are in progress is ignored. It changes neither the written values nor the number of writes.
- R10: After reset, `wr_valid` and `done` are low and `wr_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, one cycle |
| coef_in | input | 256 | 4x4 signed 16-bit DC coefficients, element (r,c) at bits (4r+c)*16 |
| qmul | input | 22 | Unsigned dequantization multiplier |
| wr_valid | output | 1 | Write strobe |
| wr_addr | output | 8 | Destination coefficient address (block*16) |
| wr_data | output | 16 | Dequantized signed value |
| done | output | 1 | Pulse after the last write |

## Verification
The assertions check the stream framing on every cycle. The first write of a burst must trace back to an accepted `start`. Back-to-back writes must never repeat an address. `done` must be a lone pulse that directly follows a write and never coincides with one.

The arithmetic can only be shown by the bench's scenarios, which compare each write against an integer model. These scenarios cover:
- the Hadamard signs and ordering;
- 16-bit wrap of the sums;
- both rounding paths, on either side of the 32767 boundary;
- clamping;
- the interleaved block order;
- the ignoring of a second `start` during a burst.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
  localparam int ELEM_W   = 16;
  localparam int N_SIDE   = 4;
  localparam int N_ELEM   = N_SIDE * N_SIDE;
  localparam int IDX_W    = $clog2(N_ELEM);
  localparam int QMUL_W   = 22;
  localparam int SMALL_SH = 8;
  localparam int BIG_PRE  = 7;
  localparam int MULT_W   = QMUL_W - BIG_PRE;
  localparam int PROD_W   = 2 * ELEM_W;
  localparam int SMALL_LIM = (1 << MULT_W) - 1;

  typedef logic signed [ELEM_W-1:0] elem_t;
endpackage

// File: rtl/ldc_walsh4.sv
module ldc_walsh4
  import ldc_pkg::*;
(
  input  elem_t a,
  input  elem_t b,
  input  elem_t c,
  input  elem_t d,
  output elem_t y0,
  output elem_t y1,
  output elem_t y2,
  output elem_t y3
);
  elem_t s_ab, s_cd, d_ab, d_cd;

  // first butterfly layer
  always_comb begin
    s_ab = a + b;
    s_cd = c + d;
    d_ab = a - b;
    d_cd = c - d;
  end

  // second butterfly layer
  always_comb begin
    y0 = s_ab + s_cd;
    y1 = s_ab - s_cd;
    y2 = d_ab - d_cd;
    y3 = d_ab + d_cd;
  end
endmodule

// File: rtl/ldc_dequant.sv
module ldc_dequant
  import ldc_pkg::*;
(
  input  elem_t              val,
  input  logic [QMUL_W-1:0]  qmul,
  output elem_t              res
);
  localparam logic signed [PROD_W-1:0] MAX_V = PROD_W'(2**(ELEM_W-1) - 1);
  localparam logic signed [PROD_W-1:0] MIN_V = -PROD_W'(2**(ELEM_W-1));

  logic                     big;
  logic [MULT_W-1:0]        mult;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rnd;
  logic signed [PROD_W-1:0] scaled;

  always_comb begin
    big  = (qmul > QMUL_W'(SMALL_LIM));
    // large multipliers are pre-shifted so the product keeps its headroom
    mult = big ? qmul[QMUL_W-1:BIG_PRE] : qmul[MULT_W-1:0];
    prod = PROD_W'(val) * $signed({1'b0, mult});
    if (big) begin
      rnd    = prod + PROD_W'(1 << (SMALL_SH - BIG_PRE - 1));
      scaled = rnd >>> (SMALL_SH - BIG_PRE);
    end else begin
      rnd    = prod + PROD_W'(1 << (SMALL_SH - 1));
      scaled = rnd >>> SMALL_SH;
    end
    if (scaled > MAX_V)      res = elem_t'(MAX_V);
    else if (scaled < MIN_V) res = elem_t'(MIN_V);
    else                     res = elem_t'(scaled);
  end
endmodule

// File: rtl/ldc_hadamard_dequant.sv
module ldc_hadamard_dequant
  import ldc_pkg::*;
#(
  parameter  int BLK_STRIDE = 16,
  localparam int ADDR_W     = $clog2(N_ELEM * BLK_STRIDE)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [N_ELEM*ELEM_W-1:0]   coef_in,
  input  logic [QMUL_W-1:0]          qmul,
  output logic                       wr_valid,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [ELEM_W-1:0]          wr_data,
  output logic                       done
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // operand capture
  logic [N_ELEM*ELEM_W-1:0] coef_q;
  logic [QMUL_W-1:0]        qmul_q;
  logic                     accept;

  always_ff @(posedge clk) begin
    if (accept) begin
      coef_q <= coef_in;
      qmul_q <= qmul;
    end
  end

  // two-pass transform
  elem_t x [N_SIDE][N_SIDE];
  elem_t g [N_SIDE][N_SIDE];
  elem_t f [N_SIDE][N_SIDE];

  for (genvar e = 0; e < N_ELEM; e++) begin : g_unpack
    assign x[e / N_SIDE][e % N_SIDE] = elem_t'(coef_q[e*ELEM_W +: ELEM_W]);
  end

  for (genvar r = 0; r < N_SIDE; r++) begin : g_row
    ldc_walsh4 u_row (
      .a (x[r][0]), .b (x[r][1]), .c (x[r][2]), .d (x[r][3]),
      .y0(g[r][0]), .y1(g[r][1]), .y2(g[r][2]), .y3(g[r][3])
    );
  end

  for (genvar j = 0; j < N_SIDE; j++) begin : g_col
    ldc_walsh4 u_col (
      .a (g[0][j]), .b (g[1][j]), .c (g[2][j]), .d (g[3][j]),
      .y0(f[0][j]), .y1(f[1][j]), .y2(f[2][j]), .y3(f[3][j])
    );
  end

  // sequencer state
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_q, last_d;
  logic             valid_d, done_d;
  logic [ADDR_W-1:0] addr_d;
  elem_t            sel_v, deq_v;
  logic [IDX_W-1:0] blk;

  assign accept = start && !busy_q;

  always_comb begin
    sel_v = f[idx_q[3:2]][idx_q[1:0]];
    // block = row-pair*8 + col-pair*4 + row-lsb*2 + col-lsb
    blk   = {idx_q[3], idx_q[1], idx_q[2], idx_q[0]};
  end

  ldc_dequant u_deq (
    .val (sel_v),
    .qmul(qmul_q),
    .res (deq_v)
  );

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == IDX_W'(N_ELEM - 1)) busy_d = 1'b0;
    end
    valid_d = busy_q;
    last_d  = busy_q && (idx_q == IDX_W'(N_ELEM - 1));
    done_d  = last_q;
    addr_d  = ADDR_W'(blk) * ADDR_W'(BLK_STRIDE);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      last_q   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      idx_q    <= idx_d;
      last_q   <= last_d;
      wr_valid <= valid_d;
      done     <= done_d;
      if (busy_q) begin
        wr_addr <= addr_d;
        wr_data <= deq_v;
      end
    end
  end
endmodule

// File: rtl/ldc_hadamard_dequant_chk.sv
module ldc_hadamard_dequant_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done
);
  // R1: a burst only begins two edges after a start strobe was presented
  a_r1_burst_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(start, 2));

  // R7: consecutive writes target different blocks
  a_r7_addr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid)) |-> (wr_addr != $past(wr_addr)));

  // R8: done directly follows a write and never overlaps one
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_valid) && !wr_valid));

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ldc_hadamard_dequant ldc_hadamard_dequant_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .wr_valid(wr_valid),
  .wr_addr (wr_addr),
  .done    (done)
);

// File: tb/ldc_hadamard_dequant_tb_top.sv
module ldc_hadamard_dequant_tb_top;
  logic         clk;
  logic         rst_n;
  logic         start;
  logic [255:0] coef_in;
  logic [21:0]  qmul;
  logic         wr_valid;
  logic [7:0]   wr_addr;
  logic [15:0]  wr_data;
  logic         done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int exp_v [16];
  int blk_map [16] = '{0,1,4,5,2,3,6,7,8,9,12,13,10,11,14,15};

  ldc_hadamard_dequant dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .coef_in(coef_in), .qmul(qmul),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wrap16(input longint v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int sgn(input int k, input int n);
    case (k)
      0: return 1;
      1: return (n < 2) ? 1 : -1;
      2: return (n == 0 || n == 3) ? 1 : -1;
      default: return (n == 0 || n == 2) ? 1 : -1;
    endcase
  endfunction

  function automatic int scale(input int v, input int unsigned q);
    longint p;
    if (q <= 32767) p = (longint'(v) * longint'(q) + 128) >>> 8;
    else            p = (longint'(v) * longint'(q >> 7) + 1) >>> 1;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  // integer model from the requirements (R2, R3, R4, R5, R6)
  task automatic model(input logic [255:0] cf, input int unsigned q);
    int x [4][4];
    int g [4][4];
    int fv;
    for (int e = 0; e < 16; e++) x[e/4][e%4] = wrap16(longint'($signed(cf[e*16 +: 16])));
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) begin
        longint s = 0;
        for (int c = 0; c < 4; c++) s += sgn(k, c) * x[r][c];
        g[r][k] = wrap16(s);
      end
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++) begin
        longint s = 0;
        for (int r = 0; r < 4; r++) s += sgn(k, r) * g[r][j];
        fv = wrap16(s);
        exp_v[k*4 + j] = scale(fv, q);
      end
  endtask

  task automatic run_op(input logic [255:0] cf, input int unsigned q,
                        input string req, input bit poke);
    model(cf, q);
    @(negedge clk);
    coef_in = cf; qmul = q[21:0]; start = 1;
    @(negedge clk);
    start = 0;
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      chk(wr_valid === 1'b1, "R1 write strobe", int'(wr_valid), 1);
      chk(wr_addr === 8'(blk_map[n] * 16), "R7 address order", int'(wr_addr), blk_map[n] * 16);
      chk($signed(wr_data) == exp_v[n], req, int'($signed(wr_data)), exp_v[n]);
      if (poke && n == 5) begin start = 1; coef_in = ~cf; qmul = 22'd1; end
      if (poke && n == 6) begin start = 0; end
    end
    @(negedge clk);
    chk(done === 1'b1, "R8 done after last write", int'(done), 1);
    chk(wr_valid === 1'b0, "R8 no write with done", int'(wr_valid), 0);
    @(negedge clk);
    chk(done === 1'b0, "R8 done single pulse", int'(done), 0);
    chk(wr_valid === 1'b0, "R9 no extra writes", int'(wr_valid), 0);
  endtask

  function automatic logic [255:0] one_dc(input int v);
    logic [255:0] cf = '0;
    cf[15:0] = 16'(v);
    return cf;
  endfunction

  function automatic logic [255:0] rnd_small();
    logic [255:0] cf;
    for (int e = 0; e < 16; e++) cf[e*16 +: 16] = 16'($signed(int'($urandom_range(0, 400)) - 200));
    return cf;
  endfunction

  task automatic t_reset();
    chk(wr_valid === 1'b0, "R10 reset valid", int'(wr_valid), 0);
    chk(done === 1'b0, "R10 reset done", int'(done), 0);
    chk(wr_data === 16'd0, "R10 reset data", int'(wr_data), 0);
  endtask

  task automatic t_dc_only();
    run_op(one_dc(300), 256, "R2 single DC spreads", 0);
    run_op(one_dc(-77), 1000, "R4 negative rounding", 0);
  endtask

  task automatic t_signs();
    logic [255:0] cf = '0;
    for (int e = 0; e < 16; e++) cf[e*16 +: 16] = 16'(e * 3 - 20 + (e % 3) * 11);
    run_op(cf, 256, "R2 sign pattern", 0);
  endtask

  task automatic t_random();
    for (int t = 0; t < 4; t++) run_op(rnd_small(), $urandom_range(1, 32767), "R4 random small qmul", 0);
    for (int t = 0; t < 3; t++) run_op(rnd_small(), $urandom_range(32768, 4194303), "R5 random large qmul", 0);
  endtask

  task automatic t_boundary();
    logic [255:0] cf = rnd_small();
    run_op(cf, 32767, "R4 qmul at limit", 0);
    run_op(cf, 32768, "R5 qmul above limit", 0);
    run_op(cf, 32895, "R5 qmul above limit plus 127", 0);
  endtask

  task automatic t_saturate();
    run_op(one_dc(1000), 4194303, "R6 clamp high", 0);
    run_op(one_dc(-1000), 4194303, "R6 clamp low", 0);
  endtask

  task automatic t_wrap();
    logic [255:0] cf;
    for (int e = 0; e < 16; e++) cf[e*16 +: 16] = 16'd4096;
    run_op(cf, 256, "R3 sum wraps", 0);
    for (int e = 0; e < 16; e++) cf[e*16 +: 16] = 16'h7000;
    run_op(cf, 300, "R3 large wrap", 0);
  endtask

  task automatic t_busy_ignore();
    run_op(rnd_small(), 5000, "R9 start during burst ignored", 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; coef_in = '0; qmul = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_dc_only();
    t_signs();
    t_random();
    t_boundary();
    t_saturate();
    t_wrap();
    t_busy_ignore();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule